// File: doc/BRIEF.md
# Multicast Queue Admission and Priority Mapping

This block takes multicast forwarding results and places them on the per-port multicast transmit queues. Each result carries a buffer handle, a 3-bit transmit priority and a bitmap of destination ports. The block first checks global buffer pressure. When buffer usage plus reservations reaches a limit, the whole frame is discarded and its handle is handed back on the release output.

Otherwise the block walks the destination bitmap one port per cycle, lowest port first. For each port it folds the 8-level priority onto that port's smaller set of queues. If the selected queue is full, the frame is dropped at that port only. If not, the handle is written into that queue. Each queue is a physical FIFO of handles whose depth depends on its position. While some destinations still hold the buffer, the handle is not released. If every destination drops, the handle is released so the buffer is not lost.

Ports below `N_LO` are low-speed ports with two queues each. The `N_HI` ports above them are high-speed ports with four queues each. Queue number 0 is always the lowest priority.

Top module: `mcq_admit`

## Requirements
- R1: When `fdb_used + fdb_resv >= FDB_LIMIT` at acceptance, no queue is written, `busy` stays low, and `rel_valid` is high for one cycle, starting one cycle after the accepting edge, with `rel_handle` equal to the accepted handle.
- R2: Otherwise, `busy` is high from one cycle after acceptance for exactly as many cycles as the bitmap has set bits. In each of those cycles `evt_valid` is high, `evt_port` names one destination, and the destinations are visited in ascending port number.
- R3: A destination whose selected queue holds as many entries as its depth is reported with `evt_drop`=1, and its queue is left unchanged. The other destinations receive the handle. If at least one destination received it, `rel_valid` stays low.
- R4: If every destination of a globally admitted frame is dropped, `rel_valid` pulses with the handle in the cycle after the last destination cycle.
- R5: Priority folding: a port numbered below `N_LO` uses queue `prio[2]`; any other port uses queue `prio[2:1]`. A larger queue number means a higher priority.
- R6: Queue 0 of every port holds `DEPTH_BIG` entries. Every other queue holds `DEPTH_SMALL` entries.
- R7: `deq_valid` and `deq_handle` show, combinationally, the oldest entry of the queue selected by `deq_port` and `deq_q`. `deq_en` removes that entry at the clock edge. Entries leave each queue in arrival order.
- R8: After reset, `busy` and `rel_valid` are low and every queue is empty.
- R9: `req_ready` equals `!busy`. A request presented while busy is ignored and writes nothing.
- R10: A globally admitted request with an all-zero destination bitmap releases its handle one cycle after acceptance, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Multicast result present |
| req_ready | output | 1 | Result accepted when high |
| req_handle | input | HW | Frame buffer handle |
| req_prio | input | 3 | Transmit priority, 7 highest |
| req_dest | input | N_LO+N_HI | Destination port bitmap |
| fdb_used | input | BW | Buffers in use |
| fdb_resv | input | BW | Buffers reserved |
| busy | output | 1 | Destinations being processed |
| evt_valid | output | 1 | Destination handled this cycle |
| evt_port | output | PW | Port handled this cycle |
| evt_drop | output | 1 | That port dropped the frame |
| rel_valid | output | 1 | Release the handle |
| rel_handle | output | HW | Handle to release |
| deq_port | input | PW | Port to read |
| deq_q | input | 2 | Queue number within the port |
| deq_en | input | 1 | Pop the selected queue |
| deq_valid | output | 1 | Selected queue not empty |
| deq_handle | output | HW | Head of the selected queue |

## Verification
The assertions assume that `deq_en` is raised only while `deq_valid` is high. They also assume that `req_prio` and `req_dest` are known whenever `req_valid` is high. The stimulus drives requests and pops only at falling edges. It pops a queue only after checking that `deq_valid` is high. For low-speed ports it uses only queue numbers 0 and 1. The stimulus deliberately presents one request while the block is busy, to confirm that the request is ignored.

// File: rtl/mcq_admit.sv
module mcq_admit #(
  parameter int N_LO        = 16,
  parameter int N_HI        = 2,
  parameter int HW          = 12,
  parameter int BW          = 12,
  parameter int FDB_LIMIT   = 3500,
  parameter int DEPTH_SMALL = 32,
  parameter int DEPTH_BIG   = 64,
  localparam int NP  = N_LO + N_HI,
  localparam int PW  = $clog2(NP),
  localparam int NQ  = N_LO * 2 + N_HI * 4,
  localparam int QIW = $clog2(NQ),
  localparam int AW  = $clog2(DEPTH_BIG),
  localparam int CW  = $clog2(DEPTH_BIG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [HW-1:0] req_handle,
  input  logic [2:0]    req_prio,
  input  logic [NP-1:0] req_dest,
  input  logic [BW-1:0] fdb_used,
  input  logic [BW-1:0] fdb_resv,
  output logic          busy,
  output logic          evt_valid,
  output logic [PW-1:0] evt_port,
  output logic          evt_drop,
  output logic          rel_valid,
  output logic [HW-1:0] rel_handle,
  input  logic [PW-1:0] deq_port,
  input  logic [1:0]    deq_q,
  input  logic          deq_en,
  output logic          deq_valid,
  output logic [HW-1:0] deq_handle
);

  function automatic logic [QIW-1:0] qindex(input logic [PW-1:0] p, input logic [1:0] qn);
    int r;
    if (int'(p) < N_LO) r = int'(p) * 2 + int'(qn[0]);
    else r = N_LO * 2 + (int'(p) - N_LO) * 4 + int'(qn);
    return r[QIW-1:0];
  endfunction

  logic [NP-1:0]  pend;
  logic [HW-1:0]  h_r;
  logic [2:0]     pr_r;
  logic           any_enq;
  logic [PW-1:0]  cur_port;
  logic [1:0]     cur_qn;
  logic [QIW-1:0] cur_qi, deq_qi;
  logic           last, accept, gdrop, deq_ok;
  logic [NQ-1:0]  full;
  logic [CW-1:0]  cnt  [NQ];
  logic [HW-1:0]  head [NQ];

  always_comb begin
    cur_port = '0;
    for (int k = NP - 1; k >= 0; k--)
      if (pend[k]) cur_port = k[PW-1:0];
  end

  assign cur_qn    = (int'(cur_port) < N_LO) ? {1'b0, pr_r[2]} : pr_r[2:1];
  assign cur_qi    = qindex(cur_port, cur_qn);
  assign last      = (pend & ~(NP'(1) << cur_port)) == '0;
  assign evt_valid = busy;
  assign evt_port  = cur_port;
  assign evt_drop  = busy && full[cur_qi];
  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign gdrop     = ({1'b0, fdb_used} + {1'b0, fdb_resv}) >= (BW+1)'(FDB_LIMIT);

  assign deq_ok     = (int'(deq_port) < NP) && ((int'(deq_port) >= N_LO) || !deq_q[1]);
  assign deq_qi     = qindex(deq_port, deq_q);
  assign deq_valid  = deq_ok && cnt[deq_qi] != '0;
  assign deq_handle = head[deq_qi];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend       <= '0;
      h_r        <= '0;
      pr_r       <= '0;
      any_enq    <= 1'b0;
      rel_valid  <= 1'b0;
      rel_handle <= '0;
    end else begin
      rel_valid <= 1'b0;
      if (accept) begin
        h_r  <= req_handle;
        pr_r <= req_prio;
        if (gdrop || req_dest == '0) begin
          rel_valid  <= 1'b1;
          rel_handle <= req_handle;
        end else begin
          busy    <= 1'b1;
          pend    <= req_dest;
          any_enq <= 1'b0;
        end
      end else if (busy) begin
        pend[cur_port] <= 1'b0;
        if (!evt_drop) any_enq <= 1'b1;
        if (last) begin
          busy <= 1'b0;
          if (evt_drop && !any_enq) begin
            rel_valid  <= 1'b1;
            rel_handle <= h_r;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NQ; i++) begin : g_q
    localparam bit IS_LO = i < N_LO * 2;
    localparam int QN    = IS_LO ? (i % 2) : ((i - N_LO * 2) % 4);
    localparam int DEP   = (QN == 0) ? DEPTH_BIG : DEPTH_SMALL;
    logic [HW-1:0] mem [DEP];
    logic [AW-1:0] wp, rp;
    logic          wr, rd;

    assign wr      = busy && !full[i] && cur_qi == QIW'(i);
    assign rd      = deq_en && deq_valid && deq_qi == QIW'(i);
    assign full[i] = cnt[i] == CW'(DEP);
    assign head[i] = mem[rp];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp     <= '0;
        rp     <= '0;
        cnt[i] <= '0;
      end else begin
        if (wr) wp <= (int'(wp) == DEP - 1) ? '0 : wp + 1'b1;
        if (rd) rp <= (int'(rp) == DEP - 1) ? '0 : rp + 1'b1;
        cnt[i] <= cnt[i] + CW'(wr) - CW'(rd);
      end
    end

    always_ff @(posedge clk)
      if (wr) mem[wp] <= h_r;

    p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[i] <= CW'(DEP));
    p_full_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full[i] && !rd |=> full[i]);
  end

  p_gdrop_rel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && gdrop |=> rel_valid && !busy && rel_handle == $past(req_handle));
  p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && $countones(pend) == $past($countones(pend)) - 1);
  p_partial_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && last && (any_enq || !evt_drop) |=> !rel_valid);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> h_r == $past(h_r));
  p_rel_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> !rel_valid || $past(accept));

endmodule

// File: tb/tb_mcq_admit.sv
module tb_mcq_admit;
  localparam int CLK_P = 10;
  localparam int N_LO = 2, N_HI = 1, NP = 3, HW = 8, BW = 8;
  localparam int DS = 2, DB = 4, LIM = 200;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [HW-1:0] req_handle = 0;
  logic [2:0] req_prio = 0;
  logic [NP-1:0] req_dest = 0;
  logic [BW-1:0] fdb_used = 0, fdb_resv = 0;
  logic busy, evt_valid, evt_drop, rel_valid, deq_valid;
  logic [1:0] evt_port;
  logic [HW-1:0] rel_handle, deq_handle;
  logic [1:0] deq_port = 0;
  logic [1:0] deq_q = 0;
  logic deq_en = 0;

  int total = 0, bad = 0;
  int ncyc, got_rel, rel_h;
  int ep [8];
  int ed [8];
  int hcnt = 1;

  always #(CLK_P/2) clk = ~clk;

  mcq_admit #(.N_LO(N_LO), .N_HI(N_HI), .HW(HW), .BW(BW), .FDB_LIMIT(LIM),
              .DEPTH_SMALL(DS), .DEPTH_BIG(DB)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int h, input int dest, input int pr, input bit extra);
    @(negedge clk);
    req_valid = 1; req_handle = HW'(h); req_dest = NP'(dest); req_prio = 3'(pr);
    @(negedge clk);
    req_valid = 0;
    ncyc = 0; got_rel = 0; rel_h = -1;
    while (busy) begin
      if (ncyc < 8) begin ep[ncyc] = evt_port; ed[ncyc] = evt_drop; end
      ncyc++;
      if (extra && ncyc == 1) begin
        req_valid = 1; req_handle = 8'hEE; req_dest = 3'b111; req_prio = 0;
      end
      @(negedge clk);
      req_valid = 0;
    end
    if (rel_valid) begin got_rel = 1; rel_h = rel_handle; end
  endtask

  task automatic peek(input int p, input int q, input bit pop, output int v, output int h);
    deq_port = 2'(p); deq_q = 2'(q);
    #1;
    v = deq_valid; h = deq_handle;
    if (pop && deq_valid) begin
      @(negedge clk); deq_en = 1;
      @(negedge clk); deq_en = 0;
    end
  endtask

  function automatic int qof(input int p, input int pr);
    return p < N_LO ? pr >> 2 : pr >> 1;
  endfunction

  function automatic int depof(input int q);
    return q == 0 ? DB : DS;
  endfunction

  function automatic int prof(input int p, input int q);
    return p < N_LO ? q << 2 : q << 1;
  endfunction

  task automatic all_empty(input string req);
    int v, h, nq;
    for (int p = 0; p < NP; p++) begin
      nq = p < N_LO ? 2 : 4;
      for (int q = 0; q < nq; q++) begin
        peek(p, q, 0, v, h);
        chk(v == 0, req, v, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R8 busy", busy, 0);
    chk(rel_valid == 0, "R8 rel", rel_valid, 0);
    all_empty("R8 empty");

    // R5 mapping sweep
    for (int p = 0; p < NP; p++)
      for (int pr = 0; pr < 8; pr++) begin
        send(hcnt, 1 << p, pr, 0);
        chk(ncyc == 1, "R2 one cycle", ncyc, 1);
        chk(got_rel == 0, "R3 no release", got_rel, 0);
        peek(p, qof(p, pr), 1, v, h);
        chk(v == 1 && h == hcnt, "R5 queue mapping", h, hcnt);
        hcnt++;
      end
    all_empty("R7 drained");

    // R6 depth sweep, R4 single-dest drop releases
    for (int p = 0; p < NP; p++) begin
      int nq;
      nq = p < N_LO ? 2 : 4;
      for (int q = 0; q < nq; q++) begin
        int base;
        base = hcnt;
        for (int k = 0; k <= depof(q); k++) begin
          send(hcnt, 1 << p, prof(p, q), 0);
          if (k < depof(q)) chk(ed[0] == 0, "R6 accepted", ed[0], 0);
          else begin
            chk(ed[0] == 1, "R6 full drop", ed[0], 1);
            chk(got_rel == 1 && rel_h == hcnt, "R4 release all dropped", rel_h, hcnt);
          end
          hcnt++;
        end
        for (int k = 0; k < depof(q); k++) begin
          peek(p, q, 1, v, h);
          chk(v == 1 && h == base + k, "R7 fifo order", h, base + k);
        end
        peek(p, q, 0, v, h);
        chk(v == 0, "R6 drained", v, 0);
      end
    end

    // R3 partial drop: fill port1 queue0
    for (int k = 0; k < DB; k++) begin send(100 + k, 3'b010, 0, 0); end
    send(150, 3'b111, 1, 0);
    chk(ncyc == 3, "R2 three cycles", ncyc, 3);
    chk(ep[0] == 0 && ep[1] == 1 && ep[2] == 2, "R2 ascending", ep[0]*100+ep[1]*10+ep[2], 12);
    chk(ed[0] == 0 && ed[1] == 1 && ed[2] == 0, "R3 drop pattern", ed[0]*100+ed[1]*10+ed[2], 10);
    chk(got_rel == 0, "R3 handle kept", got_rel, 0);
    peek(0, 0, 1, v, h); chk(v == 1 && h == 150, "R3 port0 got", h, 150);
    peek(2, 0, 1, v, h); chk(v == 1 && h == 150, "R3 port2 got", h, 150);
    for (int k = 0; k < DB; k++) begin
      peek(1, 0, 1, v, h); chk(h == 100 + k, "R3 port1 unchanged", h, 100 + k);
    end

    // R1 global drop
    fdb_used = 8'd150; fdb_resv = 8'd50;
    send(160, 3'b111, 7, 0);
    chk(ncyc == 0, "R1 no busy", ncyc, 0);
    chk(got_rel == 1 && rel_h == 160, "R1 release", rel_h, 160);
    all_empty("R1 nothing queued");
    fdb_resv = 8'd49;
    send(161, 3'b001, 7, 0);
    chk(ncyc == 1 && got_rel == 0, "R1 below limit admits", got_rel, 0);
    peek(0, 1, 1, v, h); chk(h == 161, "R1 admitted", h, 161);
    fdb_used = 0; fdb_resv = 0;

    // R10 empty bitmap
    send(170, 0, 3, 0);
    chk(ncyc == 0 && got_rel == 1 && rel_h == 170, "R10 empty release", rel_h, 170);

    // R9 request while busy ignored
    send(180, 3'b111, 6, 1);
    chk(ncyc == 3, "R9 cycles", ncyc, 3);
    chk(req_ready == 1, "R9 ready idle", req_ready, 1);
    peek(0, 1, 1, v, h); chk(h == 180, "R9 p0", h, 180);
    peek(1, 1, 1, v, h); chk(h == 180, "R9 p1", h, 180);
    peek(2, 3, 1, v, h); chk(h == 180, "R9 p2", h, 180);
    all_empty("R9 no extra entries");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule